// File: doc/BRIEF.md
# Warp Barrier Controller

This block synchronises the warps of one thread block at a barrier. Each warp can send a one-cycle arrive pulse when it reaches the barrier, or a one-cycle terminate pulse when it exits. A warp that has arrived is held by its stall bit. When every warp in the block's valid mask has either arrived or terminated, a fixed release latency runs. After that latency, one release pulse is issued and all stall bits clear together.

Synchronisation works on whole warps. The block never sees individual lanes. When a warp's execution splits into serialized paths, each path sends its own arrive pulse, so one split warp can take part in two barrier episodes in a row. Terminated warps count as satisfied until their valid bit is dropped. There is no timeout: a live warp that neither arrives nor terminates holds the others for as long as that lasts. The arrival set is cleared at release, and an arrive pulse in the release cycle opens the next episode.

Top module: `warp_barrier`

## Requirements
- R1: During and directly after reset, `stall_o` is all zero and `release_o` is low.
- R2: An arrive pulse from a warp that is valid and not terminated sets that warp's bit in `stall_o` in the cycle after the pulse. The bit stays set until release.
- R3: Let the arrival or termination that completes the set be sampled at clock edge k. Then `release_o` is high for exactly one cycle after edge k+`REL_LAT`. In that same cycle every stall bit clears, except for arrivals sampled at that edge.
- R4: A terminated warp satisfies the barrier. While any valid warp is neither arrived nor terminated, no release happens, however long that lasts.
- R5: Arrive and terminate pulses on a warp whose valid bit is 0 have no effect. Such a warp never blocks release and never shows a stall bit.
- R6: An arrive pulse sampled at the same edge that produces release belongs to the next episode. The warp's stall bit stays set, and the next release follows `REL_LAT` edges later.
- R7: A further arrive pulse from a warp that is already waiting is ignored. It neither changes `stall_o` nor moves the release time.
- R8: A terminate pulse clears that warp's stall bit. When terminate and arrive occur together, terminate wins.
- R9: A block with a single live warp releases `REL_LAT` edges after its arrival. Back-to-back barriers then repeat every `REL_LAT` cycles (20 by default).
- R10: A terminated state lasts until the warp's valid bit is dropped. After the valid bit returns, the warp is live again and must arrive or terminate before release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| warp_valid | input | N_WARPS | Warps that belong to the block |
| arrive | input | N_WARPS | Per-warp barrier arrival pulse |
| term | input | N_WARPS | Per-warp termination pulse |
| stall_o | output | N_WARPS | Per-warp hold, set while waiting at the barrier |
| release_o | output | 1 | One-cycle pulse when the waiting warps are freed |

## Verification
If a bit is lost from the arrival set, that warp drops its stall before release, or release fires one latency too early. Either shows at the ports on the next cycle. If a terminated flag is lost or left stuck, the barrier either hangs or releases with a live warp outstanding, and this shows as a missed or unexpected release pulse at the exact predicted cycle. An off-by-one in the latency counter moves every release by one cycle. The release-cycle scoreboard catches this on the first episode.

// File: rtl/wbar_pkg.sv
package wbar_pkg;
   function automatic int cnt_bits(input int lat);
      return (lat <= 2) ? 1 : $clog2(lat);
   endfunction
endpackage

// File: rtl/wbar_track.sv
module wbar_track #(
   parameter int N_WARPS = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_WARPS-1:0] warp_valid,
   input  logic [N_WARPS-1:0] arrive,
   input  logic [N_WARPS-1:0] term,
   input  logic               fire,
   output logic [N_WARPS-1:0] waiting,
   output logic               done
);
   logic [N_WARPS-1:0] sat;

   for (genvar w = 0; w < N_WARPS; w++) begin : g_warp
      logic arr_q, dead_q, hit;
      assign hit = arrive[w] & warp_valid[w] & ~term[w] & ~dead_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            arr_q  <= 1'b0;
            dead_q <= 1'b0;
         end else begin
            dead_q <= (dead_q | term[w]) & warp_valid[w];
            if (fire) arr_q <= hit;
            else      arr_q <= (arr_q | hit) & warp_valid[w] & ~term[w];
         end
      end
      assign waiting[w] = arr_q;
      assign sat[w]     = arr_q | dead_q | ~warp_valid[w];
   end

   assign done = (&sat) & (|waiting);
endmodule

// File: rtl/wbar_timer.sv
module wbar_timer #(
   parameter int REL_LAT = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic done,
   output logic fire
);
   localparam int CW = wbar_pkg::cnt_bits(REL_LAT);

   if (REL_LAT == 1) begin : g_direct
      assign fire = done;
   end else begin : g_count
      logic [CW-1:0] cnt;
      assign fire = done && (cnt == CW'(REL_LAT - 1));
      always_ff @(posedge clk) begin
         if (!rst_n)              cnt <= '0;
         else if (!done || fire)  cnt <= '0;
         else                     cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/warp_barrier.sv
module warp_barrier #(
   parameter int N_WARPS = 16,
   parameter int REL_LAT = 20
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_WARPS-1:0] warp_valid,
   input  logic [N_WARPS-1:0] arrive,
   input  logic [N_WARPS-1:0] term,
   output logic [N_WARPS-1:0] stall_o,
   output logic               release_o
);
   if (N_WARPS < 1) begin : g_bad_warps
      $error("warp_barrier: N_WARPS must be at least 1");
   end
   if (REL_LAT < 1) begin : g_bad_lat
      $error("warp_barrier: REL_LAT must be at least 1");
   end

   logic done, fire, rel_q;

   wbar_track #(.N_WARPS(N_WARPS)) u_track (
      .clk(clk), .rst_n(rst_n), .warp_valid(warp_valid), .arrive(arrive),
      .term(term), .fire(fire), .waiting(stall_o), .done(done)
   );

   wbar_timer #(.REL_LAT(REL_LAT)) u_timer (
      .clk(clk), .rst_n(rst_n), .done(done), .fire(fire)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) rel_q <= 1'b0;
      else        rel_q <= fire;
   end
   assign release_o = rel_q;
endmodule

// File: rtl/warp_barrier_chk.sv
module warp_barrier_chk #(
   parameter int N_WARPS = 16,
   parameter int REL_LAT = 20
) (
   input logic               clk,
   input logic               rst_n,
   input logic [N_WARPS-1:0] warp_valid,
   input logic [N_WARPS-1:0] arrive,
   input logic [N_WARPS-1:0] term,
   input logic [N_WARPS-1:0] stall_o,
   input logic               release_o
);
   // R2
   stall_needs_arrive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((stall_o & ~$past(stall_o) & ~$past(arrive)) == '0));
   // R5
   no_invalid_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((stall_o & ~$past(warp_valid)) == '0));
   // R8
   term_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((stall_o & $past(term)) == '0));
   // R3
   release_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      release_o |-> ((stall_o & ~$past(arrive)) == '0));
   // R3
   release_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (REL_LAT > 1 && release_o) |=> !release_o);
   // R4
   release_had_waiters_chk: assert property (@(posedge clk) disable iff (!rst_n)
      release_o |-> ($past(stall_o) != '0));
endmodule

bind warp_barrier warp_barrier_chk #(.N_WARPS(N_WARPS), .REL_LAT(REL_LAT)) u_chk (
   .clk(clk), .rst_n(rst_n), .warp_valid(warp_valid), .arrive(arrive),
   .term(term), .stall_o(stall_o), .release_o(release_o)
);

// File: tb/warp_barrier_tb.sv
module warp_barrier_tb;
   localparam int N   = 16;
   localparam int LAT = 20;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] warp_valid = '0, arrive = '0, term = '0;
   logic [N-1:0] stall_o;
   logic         release_o;

   int cyc = 0;
   int n_cmp = 0, n_bad = 0;
   int exp_q[$];
   bit done_run = 1'b0;

   warp_barrier #(.N_WARPS(N), .REL_LAT(LAT)) u_dut (
      .clk(clk), .rst_n(rst_n), .warp_valid(warp_valid), .arrive(arrive),
      .term(term), .stall_o(stall_o), .release_o(release_o)
   );

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, expv, cyc);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   // scoreboard monitor: release cycles against expected queue
   always @(negedge clk) begin
      if (rst_n && !done_run) begin
         if (release_o) begin
            if (exp_q.size() == 0) chk(1'b0, "R3 unexpected release", cyc, -1);
            else begin
               int e;
               e = exp_q.pop_front();
               chk(cyc == e, "R3 release cycle", cyc, e);
            end
         end else if (exp_q.size() > 0 && exp_q[0] < cyc) begin
            int e;
            e = exp_q.pop_front();
            chk(1'b0, "R3 missed release", cyc, e);
         end
      end
   end

   // driver: one-cycle pulse, optionally pushes expected release cycle
   task automatic drive(input logic [N-1:0] a, input logic [N-1:0] t, input bit completes);
      if (completes) exp_q.push_back(cyc + 1 + LAT);
      arrive = a;
      term   = t;
      @(negedge clk);
      arrive = '0;
      term   = '0;
   endtask

   task automatic wait_until(input int c);
      while (cyc < c) @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      chk(1'b0, "watchdog", cyc, 0);
      summary();
   end

   initial begin
      int r;
      repeat (3) @(negedge clk);
      chk(stall_o == '0, "R1 stall in reset", stall_o, 0);
      chk(release_o == 1'b0, "R1 release in reset", release_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(stall_o == '0, "R1 stall after reset", stall_o, 0);

      // four warps, last one terminates
      warp_valid = 16'h000F;
      @(negedge clk);
      drive(16'h0001, '0, 0);
      chk(stall_o == 16'h0001, "R2 stall set", stall_o, 16'h0001);
      drive(16'h0006, '0, 0);
      chk(stall_o == 16'h0007, "R2 stall accumulate", stall_o, 16'h0007);
      r = cyc + 1 + LAT;
      drive('0, 16'h0008, 1);
      chk(stall_o == 16'h0007, "R4 held during latency", stall_o, 16'h0007);
      wait_until(r);
      chk(release_o == 1'b1, "R3 release pulse", release_o, 1);
      chk(stall_o == '0, "R3 stall cleared", stall_o, 0);

      // invalid warp arrival and duplicate arrival
      drive(16'h0023, '0, 0);
      chk(stall_o == 16'h0003, "R5 invalid warp ignored", stall_o, 16'h0003);
      drive(16'h0001, '0, 0);
      chk(stall_o == 16'h0003, "R7 duplicate ignored", stall_o, 16'h0003);
      r = cyc + 1 + LAT;
      drive(16'h0004, '0, 1);
      wait_until(r);
      chk(stall_o == '0, "R7 release after last warp", stall_o, 0);

      // no timeout
      drive(16'h0003, '0, 0);
      repeat (3 * LAT) @(negedge clk);
      chk(stall_o == 16'h0003, "R4 no timeout", stall_o, 16'h0003);
      r = cyc + 1 + LAT;
      drive('0, 16'h0004, 1);
      wait_until(r);
      chk(stall_o == '0, "R4 release on terminate", stall_o, 0);

      // terminate wins over arrive
      drive(16'h0001, '0, 0);
      r = cyc + 1 + LAT;
      drive(16'h0002, 16'h0002, 1);
      chk(stall_o == 16'h0001, "R8 terminate wins", stall_o, 16'h0001);
      wait_until(r);
      chk(stall_o == '0, "R8 released", stall_o, 0);

      // single live warp, back-to-back
      r = cyc + 1 + LAT;
      drive(16'h0001, '0, 1);
      wait_until(r - 1);
      drive(16'h0001, '0, 1);
      chk(release_o == 1'b1, "R6 release with new arrival", release_o, 1);
      chk(stall_o == 16'h0001, "R6 arrival kept for next episode", stall_o, 16'h0001);
      wait_until(r + LAT);
      chk(stall_o == '0, "R9 back-to-back period", stall_o, 0);

      // valid drop clears terminated state
      warp_valid = '0;
      @(negedge clk);
      warp_valid = 16'h0003;
      @(negedge clk);
      drive(16'h0001, '0, 0);
      repeat (2 * LAT) @(negedge clk);
      chk(stall_o == 16'h0001, "R10 warp live again", stall_o, 16'h0001);
      r = cyc + 1 + LAT;
      drive(16'h0002, '0, 1);
      wait_until(r);
      chk(stall_o == '0, "R10 released", stall_o, 0);

      repeat (5) @(negedge clk);
      chk(exp_q.size() == 0, "R3 pending releases", exp_q.size(), 0);
      done_run = 1'b1;
      summary();
   end
endmodule